// File: doc/BRIEF.md
# Two-Wire Serial Slave Port Expander

This block is a two-wire (I2C) slave that gives an external bus master read and write access to one 8-bit output register. The register bits drive eight output pins, so a master can set those pins with a short write and read their current value back. The block runs entirely on a fast system clock. Neither bus line is ever used as a clock.

Both bus inputs pass through a synchroniser and a stable-count glitch filter before any decoding. Start, repeated start and stop conditions are found from the filtered lines. The slave answers one fixed 7-bit device address, which is set by a parameter. It drives the data line only by pulling it low through an output-enable signal. The pad and the pull-up resistor stay outside the block.

During a read, the slave watches the acknowledge bit that the master returns after each byte. If the master does not acknowledge, the slave lets go of the data line until the next start condition.

Top module: `i2cx_port_expander`

## Requirements
- R1: After synchronous active-low reset the output pins read 0x00 and `sda_oe_o` is 0 (data line released).
- R2: After a start, the slave takes 7 address bits MSB first, then a direction bit (1 = read, 0 = write). When the address equals `DEV_ADDR` (default 0x27), the slave pulls the data line low during the ninth (acknowledge) bit.
- R3: When the address differs from `DEV_ADDR`, the slave keeps the data line released for every bit slot up to the next start or stop. The output pins keep their value.
- R4: In a write transaction, every complete byte after the address byte is acknowledged by the slave. That byte, received MSB first, replaces the register, and the pins then show the last byte written.
- R5: In a read transaction, the slave sends the register MSB first. It pulls the line low for a 0 and releases it for a 1. It sends the register again after every byte that the master acknowledges.
- R6: If the master does not acknowledge a read byte (line high in the ninth slot), the slave keeps the data line released until the next start.
- R7: A repeated start restarts address decoding at once. A stop ends the transaction and releases the line. A write byte cut short by a stop leaves the register unchanged.
- R8: A pulse on either bus input that is shorter than `STABLE_CYCLES` system clocks has no effect. An extra clock edge or a false start or stop built from such a pulse is ignored.
- R9: The slave changes its data-line drive only after a falling edge of the filtered clock line. Its drive is stable for the whole time the clock line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 = pull the data line low, 0 = release it |
| gpio_o | output | 8 | Register value driven to the output pins |

## Verification
The bench checks address matching at the edges. It uses a neighbour address that differs only in the last bit and one that differs only in the first bit; a slave that compared the wrong bit range would acknowledge one of them. It ends a read with a not-acknowledge and then keeps clocking. A slave that ignored the master's acknowledge would go on pulling the line low and would corrupt the next transaction. It cuts a write byte short with a stop, and it inserts clock and data pulses just one system clock shorter than the filter window. A slave that committed partial bytes would show a changed pin value. A filter that was too short would count an extra bit or see a false stop. On every read bit the line is sampled early and late in the clock-high phase, so a slave that changed its drive on the rising edge is caught.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } xfer_state_e;

endpackage

// File: rtl/i2cx_glitch_filter.sv
module i2cx_glitch_filter #(
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CNT_W = $clog2(STABLE_CYCLES + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CNT_W-1:0]       cnt;
        logic                   clean;
    } filt_regs_t;

    filt_regs_t q, d;
    logic newest;

    assign newest = q.sync[SYNC_STAGES-1];

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], raw_i};
        if (newest != q.clean) begin
            if (q.cnt == CNT_W'(STABLE_CYCLES - 1)) begin
                d.clean = newest;
                d.cnt   = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.sync  <= '1;
            q.cnt   <= '0;
            q.clean <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign clean_o = q.clean;

    // R8: a new filtered level must already be present at the synchroniser output
    p_clean_settled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.clean != $past(q.clean)) |-> ($past(newest) == q.clean));

endmodule

// File: rtl/i2cx_bus_events.sv
module i2cx_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f_i,
    input  logic sda_f_i,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic scl_prev;
        logic sda_prev;
        logic scl_cur;
        logic sda_cur;
    } evt_regs_t;

    evt_regs_t q, d;

    always_comb begin
        d          = q;
        d.scl_prev = q.scl_cur;
        d.sda_prev = q.sda_cur;
        d.scl_cur  = scl_f_i;
        d.sda_cur  = sda_f_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign scl_lvl_o  = q.scl_cur;
    assign sda_lvl_o  = q.sda_cur;
    assign scl_rise_o = q.scl_cur & ~q.scl_prev;
    assign scl_fall_o = ~q.scl_cur & q.scl_prev;
    assign start_o    = q.scl_cur & q.scl_prev & q.sda_prev & ~q.sda_cur;
    assign stop_o     = q.scl_cur & q.scl_prev & ~q.sda_prev & q.sda_cur;

    // R7/R8: at most one bus event is reported in any cycle
    p_one_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise_o, scl_fall_o, start_o, stop_o}));

endmodule

// File: rtl/i2cx_slave_fsm.sv
module i2cx_slave_fsm
    import i2cx_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl_i,
    input  logic              sda_lvl_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    output logic              sda_oe_o,
    output logic [BYTE_W-1:0] reg_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

    typedef struct packed {
        xfer_state_e       state;
        logic [CNT_W-1:0]  bitcnt;
        logic [BYTE_W-1:0] shift;
        logic [BYTE_W-1:0] mem;
        logic              rd_dir;
        logic              host_ack;
        logic              oe;
    } slv_regs_t;

    slv_regs_t q, d;

    always_comb begin
        d = q;
        if (start_i) begin
            d.state  = ST_ADDR;
            d.bitcnt = '0;
            d.oe     = 1'b0;
        end else if (stop_i) begin
            d.state  = ST_IDLE;
            d.bitcnt = '0;
            d.oe     = 1'b0;
        end else begin
            case (q.state)
                ST_ADDR, ST_WR: begin
                    if (scl_rise_i && q.bitcnt < LAST) begin
                        d.shift  = {q.shift[BYTE_W-2:0], sda_lvl_i};
                        d.bitcnt = q.bitcnt + 1'b1;
                    end
                    if (scl_fall_i && q.bitcnt == LAST) begin
                        if (q.state == ST_ADDR) begin
                            if (q.shift[BYTE_W-1:1] == DEV_ADDR) begin
                                d.state  = ST_ADDR_ACK;
                                d.rd_dir = q.shift[0];
                                d.oe     = 1'b1;
                            end else begin
                                d.state = ST_SKIP;
                            end
                        end else begin
                            d.mem   = q.shift;
                            d.state = ST_WR_ACK;
                            d.oe    = 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall_i) begin
                        d.bitcnt = '0;
                        if (q.rd_dir) begin
                            d.state = ST_RD;
                            d.shift = q.mem;
                            d.oe    = ~q.mem[BYTE_W-1];
                        end else begin
                            d.state = ST_WR;
                            d.oe    = 1'b0;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall_i) begin
                        d.state  = ST_WR;
                        d.bitcnt = '0;
                        d.oe     = 1'b0;
                    end
                end
                ST_RD: begin
                    if (scl_rise_i && q.bitcnt < LAST) begin
                        d.bitcnt = q.bitcnt + 1'b1;
                    end
                    if (scl_fall_i && q.bitcnt != '0) begin
                        if (q.bitcnt == LAST) begin
                            d.state = ST_RD_ACK;
                            d.oe    = 1'b0;
                        end else begin
                            d.shift = {q.shift[BYTE_W-2:0], 1'b0};
                            d.oe    = ~q.shift[BYTE_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise_i) begin
                        d.host_ack = ~sda_lvl_i;
                    end
                    if (scl_fall_i) begin
                        if (q.host_ack) begin
                            d.state  = ST_RD;
                            d.bitcnt = '0;
                            d.shift  = q.mem;
                            d.oe     = ~q.mem[BYTE_W-1];
                        end else begin
                            d.state = ST_SKIP;
                            d.oe    = 1'b0;
                        end
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state    <= ST_IDLE;
            q.bitcnt   <= '0;
            q.shift    <= '0;
            q.mem      <= '0;
            q.rd_dir   <= 1'b0;
            q.host_ack <= 1'b0;
            q.oe       <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;
    assign reg_o    = q.mem;

    // R9: drive changes only after a cycle with the filtered clock low, or on start/stop
    p_drive_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.oe != $past(q.oe)) |-> ($past(!scl_lvl_i) || $past(start_i) || $past(stop_i)));

    // R3: an unaddressed slave never pulls the line
    p_skip_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SKIP) |-> !q.oe);

    // R4: a register update is always accompanied by the data acknowledge
    p_mem_on_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mem != $past(q.mem)) |-> (q.state == ST_WR_ACK && q.oe));

    // R6: leaving the master-acknowledge slot for the skip state releases the line
    p_nack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.state) == ST_RD_ACK && q.state == ST_SKIP) |-> !q.oe);

    // R7: idle after a stop means released
    p_idle_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE) |-> !q.oe);

endmodule

// File: rtl/i2cx_port_expander.sv
module i2cx_port_expander
    import i2cx_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR      = 7'h27,
    parameter int         SYNC_STAGES   = 2,
    parameter int         STABLE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [BYTE_W-1:0] gpio_o
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] clean_lines;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_p, stop_p;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_filt
        i2cx_glitch_filter #(
            .SYNC_STAGES  (SYNC_STAGES),
            .STABLE_CYCLES(STABLE_CYCLES)
        ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_lines[g]),
            .clean_o(clean_lines[g])
        );
    end

    i2cx_bus_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f_i   (clean_lines[0]),
        .sda_f_i   (clean_lines[1]),
        .scl_lvl_o (scl_lvl),
        .sda_lvl_o (sda_lvl),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start_p),
        .stop_o    (stop_p)
    );

    i2cx_slave_fsm #(
        .DEV_ADDR(DEV_ADDR)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl_i (scl_lvl),
        .sda_lvl_i (sda_lvl),
        .scl_rise_i(scl_rise),
        .scl_fall_i(scl_fall),
        .start_i   (start_p),
        .stop_i    (stop_p),
        .sda_oe_o  (sda_oe_o),
        .reg_o     (gpio_o)
    );

endmodule

// File: tb/i2cx_port_expander_tb.sv
module i2cx_port_expander_tb;
    localparam int Q = 12;
    localparam logic [6:0] OWN = 7'h27;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic g_scl = 1'b0, g_sda = 1'b0;
    logic sda_oe;
    logic [7:0] gpio;
    logic sda_line;

    int total = 0, bad = 0;
    logic [7:0] exp_reg = 8'h00;

    assign sda_line = m_sda & ~sda_oe;

    always #4 clk = ~clk;

    i2cx_port_expander u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (m_scl ^ g_scl),
        .sda_i   (sda_line ^ g_sda),
        .sda_oe_o(sda_oe),
        .gpio_o  (gpio)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rd);
        return {a, rd};
    endfunction

    // gl: 0 none, 1 short pulse on clock while low, 2 short pulse on data while high
    task automatic send_bit(input logic b, input int gl, output logic s1, output logic s2);
        tick(Q);
        m_sda = b;
        if (gl == 1) begin
            tick(2); g_scl = 1'b1; tick(3); g_scl = 1'b0; tick(Q - 5);
        end else begin
            tick(Q);
        end
        m_scl = 1'b1;
        if (gl == 2) begin
            tick(3); g_sda = 1'b1; tick(3); g_sda = 1'b0; tick(Q - 6);
        end else begin
            tick(Q);
        end
        s1 = sda_line;
        tick(Q - 1);
        s2 = sda_line;
        tick(1);
        m_scl = 1'b0;
    endtask

    task automatic do_start();
        tick(Q); m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b0;
    endtask

    task automatic do_stop();
        tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] v, input int gl_bit, input int gl, output logic acked);
        logic s1, s2;
        for (int i = 7; i >= 0; i--) send_bit(v[i], (i == gl_bit) ? gl : 0, s1, s2);
        send_bit(1'b1, 0, s1, s2);
        acked = ~s1;
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] v, output logic steady);
        logic s1, s2;
        steady = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'b1, 0, s1, s2);
            v[i] = s1;
            if (s1 != s2) steady = 1'b0;
        end
        send_bit(~give_ack, 0, s1, s2);
    endtask

    initial begin
        logic ack, steady, s1, s2;
        logic [7:0] rv;
        logic [6:0] a;
        logic rd;
        int nb;
        void'($urandom(32'd4242));

        tick(6);
        rst_n = 1'b1;
        tick(20);
        chk(gpio == 8'h00, "R1 pins after reset", gpio, 8'h00);
        chk(sda_oe == 1'b0, "R1 line released after reset", sda_oe, 0);

        // directed write
        do_start();
        put_byte(addr_byte(OWN, 1'b0), -1, 0, ack);
        chk(ack, "R2 address ack on write", ack, 1);
        put_byte(8'hA5, -1, 0, ack);
        chk(ack, "R4 data ack", ack, 1);
        do_stop();
        exp_reg = 8'hA5;
        chk(gpio == exp_reg, "R4 pins after write", gpio, exp_reg);
        chk(sda_oe == 1'b0, "R7 released after stop", sda_oe, 0);

        // read with nack, then keep clocking
        do_start();
        put_byte(addr_byte(OWN, 1'b1), -1, 0, ack);
        chk(ack, "R2 address ack on read", ack, 1);
        get_byte(1'b0, rv, steady);
        chk(rv == exp_reg, "R5 read value", rv, exp_reg);
        chk(steady, "R9 drive steady while clock high", steady, 1);
        rv = 8'h00;
        for (int i = 0; i < 9; i++) begin
            send_bit(1'b1, 0, s1, s2);
            rv[i % 8] = rv[i % 8] | ~s1;
        end
        chk(rv == 8'h00, "R6 line released after nack", rv, 0);
        do_stop();

        // multi-byte write, last byte wins
        do_start();
        put_byte(addr_byte(OWN, 1'b0), -1, 0, ack);
        put_byte(8'h12, -1, 0, ack);
        put_byte(8'h34, -1, 0, ack);
        chk(ack, "R4 second byte ack", ack, 1);
        do_stop();
        exp_reg = 8'h34;
        chk(gpio == exp_reg, "R4 last byte wins", gpio, exp_reg);

        // multi-byte read with ack
        do_start();
        put_byte(addr_byte(OWN, 1'b1), -1, 0, ack);
        get_byte(1'b1, rv, steady);
        chk(rv == exp_reg, "R5 first read byte", rv, exp_reg);
        get_byte(1'b1, rv, steady);
        chk(rv == exp_reg, "R5 repeated byte after ack", rv, exp_reg);
        get_byte(1'b0, rv, steady);
        chk(rv == exp_reg && steady, "R5 R9 third byte", rv, exp_reg);
        do_stop();

        // wrong addresses: last bit and first bit different
        do_start();
        put_byte(addr_byte(7'h26, 1'b0), -1, 0, ack);
        chk(!ack, "R3 no ack for 0x26", ack, 0);
        put_byte(8'hFF, -1, 0, ack);
        chk(!ack, "R3 no data ack", ack, 0);
        do_stop();
        do_start();
        put_byte(addr_byte(7'h67, 1'b0), -1, 0, ack);
        chk(!ack, "R3 no ack for 0x67", ack, 0);
        put_byte(8'h00, -1, 0, ack);
        do_stop();
        chk(gpio == exp_reg, "R3 pins unchanged", gpio, exp_reg);
        do_start();
        put_byte(addr_byte(7'h28, 1'b1), -1, 0, ack);
        get_byte(1'b1, rv, steady);
        chk(rv == 8'hFF && !ack, "R3 released on foreign read", rv, 8'hFF);
        do_stop();

        // repeated start after foreign address
        do_start();
        put_byte(addr_byte(7'h11, 1'b0), -1, 0, ack);
        do_start();
        put_byte(addr_byte(OWN, 1'b0), -1, 0, ack);
        chk(ack, "R7 ack after repeated start", ack, 1);
        put_byte(8'h5A, -1, 0, ack);
        exp_reg = 8'h5A;
        do_start();
        put_byte(addr_byte(OWN, 1'b1), -1, 0, ack);
        get_byte(1'b0, rv, steady);
        chk(rv == exp_reg, "R7 read after repeated start", rv, exp_reg);
        do_stop();

        // stop in the middle of a byte
        do_start();
        put_byte(addr_byte(OWN, 1'b0), -1, 0, ack);
        for (int i = 0; i < 4; i++) send_bit(1'b0, 0, s1, s2);
        do_stop();
        chk(gpio == exp_reg, "R7 partial byte dropped", gpio, exp_reg);

        // short pulses on both lines
        do_start();
        put_byte(addr_byte(OWN, 1'b0), 6, 1, ack);
        chk(ack, "R8 clock pulse ignored in address", ack, 1);
        put_byte(8'h3C, 1, 2, ack);
        chk(ack, "R8 data pulse ignored", ack, 1);
        do_stop();
        exp_reg = 8'h3C;
        chk(gpio == exp_reg, "R8 value after pulses", gpio, exp_reg);

        // constrained random traffic
        for (int t = 0; t < 36; t++) begin
            a  = ($urandom_range(0, 1) == 0) ? OWN : 7'($urandom_range(0, 127));
            rd = 1'($urandom_range(0, 1));
            nb = $urandom_range(1, 3);
            do_start();
            put_byte(addr_byte(a, rd), -1, 0, ack);
            chk(ack == (a == OWN), "R2 R3 random address", ack, (a == OWN));
            for (int k = 0; k < nb; k++) begin
                if (rd) begin
                    get_byte(k != nb - 1, rv, steady);
                    if (a == OWN) chk(rv == exp_reg && steady, "R5 random read", rv, exp_reg);
                    else chk(rv == 8'hFF, "R3 random foreign read", rv, 8'hFF);
                end else begin
                    rv = 8'($urandom_range(0, 255));
                    put_byte(rv, -1, 0, ack);
                    if (a == OWN) exp_reg = rv;
                end
            end
            do_stop();
            chk(gpio == exp_reg, "R4 random pins", gpio, exp_reg);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(190000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule